// File: doc/BRIEF.md
# Auto-Format Multiplexed Bus Register Loader

This block is a write-only register loader that sits on an 8-bit multiplexed address/data bus. It accepts either Intel-style strobes (address latch, write strobe, read strobe) or Motorola-style strobes (address strobe, data strobe, read/write select). The bus style is picked again on every address cycle from the level of the read/data-strobe line at the moment the address strobe rises. An active-low chip select gates every write.

The bus side runs with no relation to the core clock. All strobes, the chip select and the bus bytes are sampled on the core clock and delayed through matched register stages, so edges are found on synchronised copies. A write to one of three staging offsets stores a byte. A write to one of two trigger offsets copies all three staged bytes at once into the 24-bit control register or the 24-bit initialisation register. The byte written to a trigger offset is discarded. Each copy raises a one-cycle load-done pulse for its register. Each strobe level must be held for at least three core clocks.

Top module: `bus_cfg_loader`

## Requirements
- R1: On each rise of `ale_as`, the level of `rd_ds` picks the bus style: high selects Intel mode, low selects Motorola mode. After reset the block is in Intel mode until the first address-strobe rise.
- R2: On each fall of `ale_as`, `ad[2:0]` is latched as the target offset. `ad[7:3]` plays no part in addressing.
- R3: In Intel mode a write happens on a rising edge of `wr_rw`.
- R4: In Motorola mode a write happens on a falling edge of `rd_ds`, and only when `wr_rw` is low before that edge. A data-strobe fall with `wr_rw` high has no effect.
- R5: A write edge has no effect when `cs_n` is high just before it.
- R6: Offsets 0, 1 and 2 store the bus byte in staging bytes that become bits 7:0, 15:8 and 23:16 of a transfer. A staging write alone leaves both outputs and both pulses unchanged.
- R7: A write to offset 3 copies all three staging bytes into `ctrl_reg` in one cycle and raises `ctrl_load` for exactly one cycle. The byte written is ignored.
- R8: A write to offset 4 copies all three staging bytes into `init_reg` in one cycle and raises `init_load` for exactly one cycle. The byte written is ignored.
- R9: Writes to offsets 5, 6 and 7 change no staging byte, no register and no pulse.
- R10: The first `clk` rising edge that samples a write edge is counted as edge 1. The resulting register update and load pulse appear after edge 3.
- R11: A clock edge with `rst_n` low clears the staging bytes, both registers, both pulses and the latched offset.
- R12: A strobe edge of the style not in force does nothing. This covers a data-strobe fall in Intel mode and a `wr_rw` rise in Motorola mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address latch enable / address strobe |
| rd_ds | input | 1 | Read strobe (Intel) / data strobe (Motorola) |
| wr_rw | input | 1 | Write strobe (Intel) / read-write select (Motorola) |
| ad | input | 8 | Multiplexed address/data byte |
| ctrl_reg | output | 24 | Control register |
| init_reg | output | 24 | Initialisation register |
| ctrl_load | output | 1 | One-cycle pulse when ctrl_reg is loaded |
| init_load | output | 1 | One-cycle pulse when init_reg is loaded |

## Verification
The mode update and the write decode can act in the same core cycle. When the bench moves from an Intel cycle to a Motorola cycle, it drops `rd_ds` in the same clock that raises `ale_as`. The synchronised data-strobe fall therefore arrives while Intel mode is still held, and it must not count as a write even though chip select is low. The behavioural model in the bench follows the rule that a write is judged against the mode held before the edge. The model's per-clock comparison, and a stray data-strobe fall driven on purpose in Intel mode toward the control-register trigger offset, both check that no load pulse appears.

// File: rtl/bcl_pkg.sv
// Shared types for the multiplexed-bus register loader.
package bcl_pkg;
    // Bus style picked on each address-strobe rise.
    typedef enum logic {
        BUS_INTEL = 1'b0,
        BUS_MOTO  = 1'b1
    } bus_mode_e;

    // Strobe vector bit positions: {addr strobe, read/data strobe, write / r-w}.
    localparam int STB_AS = 2;
    localparam int STB_DS = 1;
    localparam int STB_RW = 0;
    localparam logic [2:0] STB_IDLE = 3'b011;
endpackage

// File: rtl/bcl_delay.sv
// Register chain that brings bus inputs into the core clock domain.
// Assumes the inputs change no more often than every few core clocks.
// The chain resets to IDLE so no false edge is seen after reset.
module bcl_delay #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    // Shift the sampled input one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/bcl_bus_decode.sv
// Bus-style detection, offset latching and write-strobe generation.
// Input: strobes after synchronisation (strb_cur). A local register keeps
// their previous sample. Chip select and the bus byte arrive one stage
// later, so they line up with the pre-edge strobe sample.
// A write is judged against the mode held before the current edge.
module bcl_bus_decode
    import bcl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strb_cur,
    input  logic [DATA_W:0]   side_pre,
    output logic              wr_stb,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output bus_mode_e         mode
);
    logic [2:0] strb_pre;
    logic       cs_pre_n;
    logic [DATA_W-1:0] ad_pre;
    logic as_rise, as_fall, rw_rise, ds_fall;

    assign cs_pre_n = side_pre[DATA_W];
    assign ad_pre   = side_pre[DATA_W-1:0];

    // Keep the previous strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_pre <= STB_IDLE;
        else        strb_pre <= strb_cur;
    end

    assign as_rise =  strb_cur[STB_AS] & ~strb_pre[STB_AS];
    assign as_fall = ~strb_cur[STB_AS] &  strb_pre[STB_AS];
    assign rw_rise =  strb_cur[STB_RW] & ~strb_pre[STB_RW];
    assign ds_fall = ~strb_cur[STB_DS] &  strb_pre[STB_DS];

    // Pick the bus style from the read/data-strobe level at address-strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= BUS_INTEL;
        else if (as_rise) mode <= strb_cur[STB_DS] ? BUS_INTEL : BUS_MOTO;
    end

    // Latch the target offset on the address-strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_sel <= '0;
        else if (as_fall) wr_sel <= ad_pre[SEL_W-1:0];
    end

    // Form a one-cycle write strobe from the edge that belongs to the current style.
    always_comb begin
        wr_stb = 1'b0;
        if (!cs_pre_n) begin
            if (mode == BUS_INTEL) wr_stb = rw_rise;
            else                   wr_stb = ds_fall & ~strb_pre[STB_RW];
        end
    end

    assign wr_data = ad_pre;
endmodule

// File: rtl/bcl_regfile.sv
// Staging bytes and the two wide registers they are committed to.
// Offset i < NUM_STAGE stores staging byte i. Offset NUM_STAGE commits to the
// control register and offset NUM_STAGE+1 to the initialisation register.
// Any other offset is ignored.
module bcl_regfile #(
    parameter int DATA_W = 8,
    parameter int NUM_STAGE = 3,
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [DATA_W*NUM_STAGE-1:0] ctrl_reg,
    output logic [DATA_W*NUM_STAGE-1:0] init_reg,
    output logic                        ctrl_load,
    output logic                        init_load
);
    localparam int REG_W = DATA_W * NUM_STAGE;
    localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_STAGE);
    localparam logic [SEL_W-1:0] INIT_SEL = SEL_W'(NUM_STAGE + 1);

    logic [REG_W-1:0] staged;
    logic hit_ctrl, hit_init;

    for (genvar g = 0; g < NUM_STAGE; g++) begin : g_stage
        logic [DATA_W-1:0] byte_q;
        // Store the bus byte when this staging offset is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   byte_q <= '0;
            else if (wr_stb && wr_sel == SEL_W'(g))       byte_q <= wr_data;
        end
        assign staged[g*DATA_W +: DATA_W] = byte_q;
    end

    assign hit_ctrl = wr_stb && (wr_sel == CTRL_SEL);
    assign hit_init = wr_stb && (wr_sel == INIT_SEL);

    // Commit staged bytes to the control register on its trigger offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_reg  <= '0;
            ctrl_load <= 1'b0;
        end else begin
            ctrl_load <= hit_ctrl;
            if (hit_ctrl) ctrl_reg <= staged;
        end
    end

    // Commit staged bytes to the initialisation register on its trigger offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_reg  <= '0;
            init_load <= 1'b0;
        end else begin
            init_load <= hit_init;
            if (hit_init) init_reg <= staged;
        end
    end
endmodule

// File: rtl/bus_cfg_loader.sv
// Write-only register loader on an 8-bit multiplexed bus that detects the
// bus style by itself. Assumes each strobe level is held at least three
// core clocks. Strobes pass two sampling stages. Chip select and the bus
// byte pass three, so they line up with the pre-edge strobe sample.
module bus_cfg_loader #(
    parameter int DATA_W = 8,
    parameter int NUM_STAGE = 3,
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ale_as,
    input  logic                        rd_ds,
    input  logic                        wr_rw,
    input  logic [DATA_W-1:0]           ad,
    output logic [DATA_W*NUM_STAGE-1:0] ctrl_reg,
    output logic [DATA_W*NUM_STAGE-1:0] init_reg,
    output logic                        ctrl_load,
    output logic                        init_load
);
    import bcl_pkg::*;

    localparam int SIDE_W = DATA_W + 1;
    localparam logic [SIDE_W-1:0] SIDE_IDLE = {1'b1, {DATA_W{1'b0}}};

    logic [2:0]        strb_cur;
    logic [SIDE_W-1:0] side_pre;
    logic              wr_stb;
    logic [SEL_W-1:0]  wr_sel;
    logic [DATA_W-1:0] wr_data;
    bus_mode_e         mode;

    bcl_delay #(.W(3), .STAGES(2), .IDLE(STB_IDLE)) u_strb_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ale_as, rd_ds, wr_rw}),
        .dout(strb_cur)
    );

    bcl_delay #(.W(SIDE_W), .STAGES(3), .IDLE(SIDE_IDLE)) u_side_sync (
        .clk(clk), .rst_n(rst_n),
        .din({cs_n, ad}),
        .dout(side_pre)
    );

    bcl_bus_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_decode (
        .clk(clk), .rst_n(rst_n),
        .strb_cur(strb_cur), .side_pre(side_pre),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data), .mode(mode)
    );

    bcl_regfile #(.DATA_W(DATA_W), .NUM_STAGE(NUM_STAGE), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_reg(ctrl_reg), .init_reg(init_reg),
        .ctrl_load(ctrl_load), .init_load(init_load)
    );
endmodule

// File: rtl/bcl_checker.sv
// Properties on the loader's outputs. Attached to the top by bind below.
module bcl_checker #(
    parameter int REG_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] ctrl_reg,
    input logic [REG_W-1:0] init_reg,
    input logic             ctrl_load,
    input logic             init_load
);
    // R7: the control load pulse lasts one cycle.
    a_r7_ctrl_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_load |=> !ctrl_load);

    // R7: the control register changes only together with its pulse.
    a_r7_ctrl_change_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg != $past(ctrl_reg)) |-> ctrl_load);

    // R8: the initialisation load pulse lasts one cycle.
    a_r8_init_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> !init_load);

    // R8: the initialisation register changes only together with its pulse.
    a_r8_init_change_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        (init_reg != $past(init_reg)) |-> init_load);

    // R7 and R8: one write commits to at most one register.
    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_load && init_load));

    // R11: an edge with reset low leaves everything cleared.
    a_r11_reset_clears: assert property (@(posedge clk)
        $past(!rst_n) |-> (ctrl_reg == '0 && init_reg == '0 && !ctrl_load && !init_load));
endmodule

bind bus_cfg_loader bcl_checker #(.REG_W(DATA_W * NUM_STAGE)) u_bcl_checker (
    .clk(clk), .rst_n(rst_n),
    .ctrl_reg(ctrl_reg), .init_reg(init_reg),
    .ctrl_load(ctrl_load), .init_load(init_load)
);

// File: tb/bus_cfg_loader_test.sv
module bus_cfg_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ale_as = 1'b0, rd_ds = 1'b1, wr_rw = 1'b1;
    logic [7:0] ad = 8'h00;
    logic [23:0] ctrl_reg, init_reg;
    logic ctrl_load, init_load;

    int checks = 0;
    int failures = 0;
    int n_ctrl = 0;
    int n_init = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale_as(ale_as), .rd_ds(rd_ds),
        .wr_rw(wr_rw), .ad(ad), .ctrl_reg(ctrl_reg), .init_reg(init_reg),
        .ctrl_load(ctrl_load), .init_load(init_load)
    );

    // ---------------- behavioural reference model ----------------
    // Sample layout: {cs_n, ale_as, rd_ds, wr_rw, ad}.
    localparam logic [11:0] IDLE_S = {1'b1, 1'b0, 1'b1, 1'b1, 8'h00};
    logic [11:0] hist [$];
    logic [7:0]  m_stage [3];
    logic [23:0] m_ctrl, m_init;
    logic        m_cl, m_il;
    bit          m_moto;
    logic [2:0]  m_sel;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model: a write event seen between samples k-1 and k shows at edge k+2.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{IDLE_S, IDLE_S, IDLE_S};
            foreach (m_stage[i]) m_stage[i] = 8'h00;
            m_ctrl = '0; m_init = '0; m_cl = 0; m_il = 0; m_moto = 0; m_sel = '0;
        end else begin
            logic [11:0] a, b;
            bit wr;
            hist.push_back({cs_n, ale_as, rd_ds, wr_rw, ad});
            if (hist.size() > 6) void'(hist.pop_front());
            a = hist[hist.size()-4];
            b = hist[hist.size()-3];
            m_cl = 0; m_il = 0;
            wr = !a[11] && ((!m_moto && !a[8] && b[8]) || (m_moto && a[9] && !b[9] && !a[8]));
            if (wr) begin
                if (m_sel < 3) m_stage[m_sel] = a[7:0];
                else if (m_sel == 3) begin m_ctrl = {m_stage[2], m_stage[1], m_stage[0]}; m_cl = 1; end
                else if (m_sel == 4) begin m_init = {m_stage[2], m_stage[1], m_stage[0]}; m_il = 1; end
            end
            if (!a[10] && b[10]) m_moto = !b[9];
            if (a[10] && !b[10]) m_sel = a[2:0];
        end
    end

    // R10: compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (ctrl_load === 1'b1) n_ctrl++;
        if (init_load === 1'b1) n_init++;
        if (rst_n && !done) begin
            chk("R10 model ctrl_reg", 32'(ctrl_reg), 32'(m_ctrl));
            chk("R10 model init_reg", 32'(init_reg), 32'(m_init));
            chk("R10 model ctrl_load", 32'(ctrl_load), 32'(m_cl));
            chk("R10 model init_load", 32'(init_load), 32'(m_il));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic gap();
        repeat (4) @(negedge clk);
    endtask

    task automatic intel_wr(input logic [7:0] addr, input logic [7:0] data, input logic cs);
        cs_n = cs; ale_as = 1; rd_ds = 1; ad = addr; gap();
        ale_as = 0; gap();
        ad = data; wr_rw = 0; gap();
        wr_rw = 1; gap();
        cs_n = 1; gap();
    endtask

    task automatic moto_wr(input logic [7:0] addr, input logic [7:0] data, input logic rw);
        cs_n = 0; rd_ds = 0; wr_rw = 1; ale_as = 1; ad = addr; gap();
        ale_as = 0; gap();
        ad = data; wr_rw = rw; gap();
        rd_ds = 1; gap();
        rd_ds = 0; gap();
        wr_rw = 1; gap();
        cs_n = 1; gap();
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0, i0;
        repeat (3) @(negedge clk);
        chk("R11 reset ctrl_reg", 32'(ctrl_reg), 32'h0);
        chk("R11 reset init_reg", 32'(init_reg), 32'h0);
        chk("R11 reset pulses", 32'({ctrl_load, init_load}), 32'h0);
        rst_n = 1; gap();

        // Intel staging only (R6), then commits.
        intel_wr(8'h00, 8'h11, 0);
        intel_wr(8'h01, 8'h22, 0);
        intel_wr(8'h02, 8'h33, 0);
        chk("R6 staging leaves ctrl_reg", 32'(ctrl_reg), 32'h0);
        chk("R6 staging leaves init_reg", 32'(init_reg), 32'h0);
        chk("R6 no pulse from staging", 32'(n_ctrl + n_init), 32'h0);
        intel_wr(8'h03, 8'hA5, 0);
        chk("R7 R3 R1 ctrl commit", 32'(ctrl_reg), 32'h332211);
        chk("R7 one ctrl pulse", 32'(n_ctrl), 32'd1);
        intel_wr(8'h04, 8'h00, 0);
        chk("R8 init commit", 32'(init_reg), 32'h332211);
        chk("R8 one init pulse", 32'(n_init), 32'd1);

        // R2: upper address bits are ignored (0xF9 selects offset 1).
        intel_wr(8'hF9, 8'h5A, 0);
        intel_wr(8'h03, 8'h00, 0);
        chk("R2 offset from ad[2:0]", 32'(ctrl_reg), 32'h335A11);

        // R5: chip select high blocks a staging write and a trigger.
        intel_wr(8'h00, 8'hEE, 1);
        c0 = n_ctrl;
        intel_wr(8'h03, 8'h00, 1);
        chk("R5 trigger with cs_n high", 32'(n_ctrl), 32'(c0));
        intel_wr(8'h03, 8'h00, 0);
        chk("R5 staging with cs_n high", 32'(ctrl_reg), 32'h335A11);

        // R12: data-strobe fall while Intel mode holds offset 3.
        c0 = n_ctrl;
        cs_n = 0; wr_rw = 0; gap();
        rd_ds = 0; gap();
        rd_ds = 1; gap();
        cs_n = 1; gap();
        wr_rw = 1; gap();
        chk("R12 ds fall ignored in Intel mode", 32'(n_ctrl), 32'(c0));

        // Motorola cycles (R1, R4); R/W rise after each is R12 in Motorola mode.
        moto_wr(8'h00, 8'h01, 0);
        moto_wr(8'h01, 8'h02, 0);
        moto_wr(8'h02, 8'h03, 0);
        moto_wr(8'h03, 8'h77, 0);
        chk("R4 R1 Motorola ctrl commit", 32'(ctrl_reg), 32'h030201);
        chk("R12 R7 single pulse per Motorola trigger", 32'(n_ctrl), 32'(c0 + 1));
        moto_wr(8'h00, 8'hFF, 1);
        moto_wr(8'h04, 8'h00, 0);
        chk("R4 read cycle writes nothing", 32'(init_reg), 32'h030201);

        // R9: offsets 5..7 have no effect.
        c0 = n_ctrl; i0 = n_init;
        moto_wr(8'h05, 8'h99, 0);
        moto_wr(8'h06, 8'h98, 0);
        moto_wr(8'h07, 8'h97, 0);
        chk("R9 no pulses", 32'(n_ctrl + n_init), 32'(c0 + i0));
        moto_wr(8'h03, 8'h00, 0);
        chk("R9 staging untouched", 32'(ctrl_reg), 32'h030201);

        // R10: cycle-exact latency of a commit.
        intel_wr(8'h02, 8'hC4, 0);
        cs_n = 0; ale_as = 1; rd_ds = 1; ad = 8'h04; gap();
        ale_as = 0; gap();
        wr_rw = 0; gap();
        wr_rw = 1;
        @(negedge clk); chk("R10 no pulse after edge 1", 32'(init_load), 32'h0);
        @(negedge clk); chk("R10 no pulse after edge 2", 32'(init_load), 32'h0);
        @(negedge clk); chk("R10 pulse after edge 3", 32'(init_load), 32'h1);
        chk("R10 init value after edge 3", 32'(init_reg), 32'hC40201);
        cs_n = 1; gap();

        // R11 mid-run reset, then R1 Intel mode until the first address strobe.
        rst_n = 0; repeat (2) @(negedge clk);
        chk("R11 mid reset ctrl_reg", 32'(ctrl_reg), 32'h0);
        chk("R11 mid reset init_reg", 32'(init_reg), 32'h0);
        rst_n = 1; gap();
        c0 = n_ctrl;
        cs_n = 0; wr_rw = 0; gap();
        rd_ds = 0; gap();
        rd_ds = 1; gap();
        cs_n = 1; gap();
        wr_rw = 1; gap();
        chk("R1 Intel after reset ignores ds fall", 32'(n_ctrl), 32'(c0));
        intel_wr(8'h03, 8'h00, 0);
        chk("R11 staging cleared", 32'(ctrl_reg), 32'h0);
        chk("R11 commit after reset pulses", 32'(n_ctrl), 32'(c0 + 1));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule